// File: doc/BRIEF.md
# Address-Filtering Multidrop Serial Receiver

This block sits behind a UART core on a shared serial bus where one master talks to many slave nodes. Every character carries an extra flag bit that tells whether it is an address or a payload byte. The block holds the node's own address and a filter flag. While the filter is armed, payload bytes are dropped in hardware, so the host sees only traffic meant for this node.

An address character is always passed to the host, whether or not it matches. When an address character equals the node address, the filter is disarmed and the following payload bytes reach the host. Any address character that does not match arms the filter again. The host can also re-arm the filter after the last payload byte it expects.

A small transmit formatter lets a master build outgoing characters with the flag bit set for addresses and cleared for payload. The filter state has no effect on it. It also reports whether the line needs two stop bits. This is the case when the flag travels in the first stop bit of a short character instead of a ninth data bit.

Top module: `mdrop_rx_filter`

## Requirements
- R1: After reset, `filter_on` is 1 and `out_valid`, `addr_match` and `tx_valid` are 0.
- R2: A received character has its flag in bit DATA_W of `rx_frame` (bit 8 by default). A flag of 1 marks an address and 0 marks payload. A payload byte whose value equals the node address never counts as a match.
- R3: While `filter_on` is 1, a payload character produces no `out_valid`, and `filter_on` stays 1.
- R4: Every address character is delivered one cycle later, with `out_valid`=1, `out_is_addr`=1 and `out_data` equal to the character.
- R5: An address character equal to `node_addr` gives a one-cycle `addr_match` pulse and clears `filter_on`, both one cycle later.
- R6: An address character that differs from `node_addr` sets `filter_on` and leaves `addr_match` at 0. This holds even while the node is selected.
- R7: While `filter_on` is 0, each payload character is delivered one cycle later, with `out_valid`=1, `out_is_addr`=0 and the byte on `out_data`.
- R8: `rearm` sets `filter_on` one cycle later. When it arrives together with a payload character, that character is dropped.
- R9: When `rearm` arrives together with an address character, the address comparison alone decides the new filter state.
- R10: `tx_req` gives `tx_valid` one cycle later, with `tx_frame` = {`tx_is_addr`, `tx_byte`}. This is the same whatever the filter state.
- R11: `tx_stop2` is 1 only when the flag is carried in the first stop bit. With the default nine-bit character it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe for a character decoded by the UART core |
| rx_frame | input | DATA_W+1 | Decoded character; the top bit is the address flag |
| node_addr | input | DATA_W | This node's address |
| rearm | input | 1 | Host request to arm the filter |
| out_valid | output | 1 | Delivered-character strobe |
| out_data | output | DATA_W | Delivered byte |
| out_is_addr | output | 1 | Delivered byte was an address character |
| addr_match | output | 1 | Pulse when an address character selected this node |
| filter_on | output | 1 | Current filter state (1 = payload dropped) |
| tx_req | input | 1 | Request to send one character |
| tx_is_addr | input | 1 | Character to send is an address |
| tx_byte | input | DATA_W | Byte to send |
| tx_valid | output | 1 | Formatted character strobe towards the UART core |
| tx_frame | output | DATA_W+1 | Formatted character with its flag in the top bit |
| tx_stop2 | output | 1 | Line must use two stop bits |

## Verification
On every cycle the assertions check how each received character class maps to the next cycle's outputs. A matching address must select the node, a foreign address must deselect it, payload must be dropped while filtered, and the filter must hold still when nothing happens. They also check the priority of `rearm` over a simultaneous payload character and the one-cycle latency of the transmit formatter. Only the bench scenarios show the values carried through, and the multi-step sequences: select, receive several bytes, then deselect by a foreign address or by the host. They also cover a payload byte that looks like the node address, and `rearm` meeting a matching address.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

  typedef enum logic [1:0] {
    EV_NONE      = 2'd0,
    EV_DATA      = 2'd1,
    EV_ADDR_HIT  = 2'd2,
    EV_ADDR_MISS = 2'd3
  } rx_event_e;

  // Classify one received character from its strobe, flag and compare result.
  function automatic rx_event_e classify(input logic valid, input logic flag,
                                         input logic same);
    if (!valid)      return EV_NONE;
    else if (!flag)  return EV_DATA;
    else if (same)   return EV_ADDR_HIT;
    else             return EV_ADDR_MISS;
  endfunction

endpackage

// File: rtl/mdrop_rx_classify.sv
module mdrop_rx_classify
  import mdrop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              rx_valid,
  input  logic [DATA_W:0]   rx_frame,
  input  logic [DATA_W-1:0] node_addr,
  output rx_event_e         ev,
  output logic [DATA_W-1:0] char_byte
);

  localparam int FLAG_POS = DATA_W;

  logic flag_bit;
  logic same_addr;

  assign flag_bit  = rx_frame[FLAG_POS];
  assign char_byte = rx_frame[DATA_W-1:0];
  assign same_addr = (char_byte == node_addr);
  assign ev        = classify(rx_valid, flag_bit, same_addr);

endmodule

// File: rtl/mdrop_filter_state.sv
module mdrop_filter_state
  import mdrop_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  rx_event_e ev,
  input  logic      rearm,
  output logic      filter_on,
  output logic      deliver,
  output logic      hit
);

  logic filter_q;
  logic filter_nxt;

  always_comb begin
    filter_nxt = filter_q;
    deliver    = 1'b0;
    hit        = 1'b0;
    case (ev)
      EV_ADDR_HIT: begin
        filter_nxt = 1'b0;
        deliver    = 1'b1;
        hit        = 1'b1;
      end
      EV_ADDR_MISS: begin
        filter_nxt = 1'b1;
        deliver    = 1'b1;
      end
      EV_DATA: begin
        if (rearm) filter_nxt = 1'b1;
        else       deliver    = ~filter_q;
      end
      default: begin
        if (rearm) filter_nxt = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) filter_q <= 1'b1;
    else        filter_q <= filter_nxt;
  end

  assign filter_on = filter_q;

endmodule

// File: rtl/mdrop_tx_frame.sv
module mdrop_tx_frame #(
  parameter int DATA_W       = 8,
  parameter bit FLAG_IN_STOP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_req,
  input  logic              tx_is_addr,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              tx_valid,
  output logic [DATA_W:0]   tx_frame,
  output logic              tx_stop2
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_frame <= '0;
    end else begin
      tx_valid <= tx_req;
      if (tx_req) tx_frame <= {tx_is_addr, tx_byte};
    end
  end

  generate
    if (FLAG_IN_STOP) begin : g_stop_flag
      assign tx_stop2 = 1'b1;
    end else begin : g_ninth_bit
      assign tx_stop2 = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/mdrop_rx_filter.sv
module mdrop_rx_filter
  import mdrop_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter bit FLAG_IN_STOP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W:0]   rx_frame,
  input  logic [DATA_W-1:0] node_addr,
  input  logic              rearm,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_is_addr,
  output logic              addr_match,
  output logic              filter_on,
  input  logic              tx_req,
  input  logic              tx_is_addr,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              tx_valid,
  output logic [DATA_W:0]   tx_frame,
  output logic              tx_stop2
);

  rx_event_e         rx_ev;
  logic [DATA_W-1:0] char_byte;
  logic              deliver_w;
  logic              hit_w;

  mdrop_rx_classify #(.DATA_W(DATA_W)) u_classify (
    .rx_valid  (rx_valid),
    .rx_frame  (rx_frame),
    .node_addr (node_addr),
    .ev        (rx_ev),
    .char_byte (char_byte)
  );

  mdrop_filter_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (rx_ev),
    .rearm     (rearm),
    .filter_on (filter_on),
    .deliver   (deliver_w),
    .hit       (hit_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_is_addr <= 1'b0;
      addr_match  <= 1'b0;
    end else begin
      out_valid  <= deliver_w;
      addr_match <= hit_w;
      if (deliver_w) begin
        out_data    <= char_byte;
        out_is_addr <= (rx_ev != EV_DATA);
      end
    end
  end

  mdrop_tx_frame #(.DATA_W(DATA_W), .FLAG_IN_STOP(FLAG_IN_STOP)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_req     (tx_req),
    .tx_is_addr (tx_is_addr),
    .tx_byte    (tx_byte),
    .tx_valid   (tx_valid),
    .tx_frame   (tx_frame),
    .tx_stop2   (tx_stop2)
  );

endmodule

// File: rtl/mdrop_rx_filter_chk.sv
module mdrop_rx_filter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic [DATA_W:0]   rx_frame,
  input logic [DATA_W-1:0] node_addr,
  input logic              rearm,
  input logic              out_valid,
  input logic              out_is_addr,
  input logic              addr_match,
  input logic              filter_on,
  input logic              tx_req,
  input logic              tx_valid,
  input logic              deliver_w
);

  logic addr_in;
  logic data_in;
  logic same;

  assign addr_in = rx_valid &&  rx_frame[DATA_W];
  assign data_in = rx_valid && !rx_frame[DATA_W];
  assign same    = (rx_frame[DATA_W-1:0] == node_addr);

  // R3
  filtered_data_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_in && filter_on |=> !out_valid && filter_on);

  // R4
  addr_delivered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_in |=> out_valid && out_is_addr);

  // R5
  addr_hit_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_in && same |=> addr_match && !filter_on);

  // R5
  match_implies_delivery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |-> out_valid && out_is_addr);

  // R6
  addr_miss_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_in && !same |=> filter_on && !addr_match);

  // R7
  open_data_delivered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_in && !filter_on && !rearm |=> out_valid && !out_is_addr);

  // R8
  rearm_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm && !addr_in |=> filter_on && !out_valid);

  // R8
  filter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid && !rearm |=> $stable(filter_on));

  // R4
  deliver_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deliver_w |=> out_valid);

  // R10
  tx_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> tx_valid);

  // R10
  tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_req |=> !tx_valid);

endmodule

bind mdrop_rx_filter mdrop_rx_filter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_valid    (rx_valid),
  .rx_frame    (rx_frame),
  .node_addr   (node_addr),
  .rearm       (rearm),
  .out_valid   (out_valid),
  .out_is_addr (out_is_addr),
  .addr_match  (addr_match),
  .filter_on   (filter_on),
  .tx_req      (tx_req),
  .tx_valid    (tx_valid),
  .deliver_w   (deliver_w)
);

// File: tb/mdrop_rx_filter_test.sv
`timescale 1ns/1ps
module mdrop_rx_filter_test;

  localparam int DW = 8;
  localparam logic [DW-1:0] NODE = 8'h5A;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_valid = 1'b0;
  logic [DW:0]   rx_frame = '0;
  logic [DW-1:0] node_addr = NODE;
  logic          rearm = 1'b0;
  logic          out_valid, out_is_addr, addr_match, filter_on;
  logic [DW-1:0] out_data;
  logic          tx_req = 1'b0, tx_is_addr = 1'b0;
  logic [DW-1:0] tx_byte = '0;
  logic          tx_valid, tx_stop2;
  logic [DW:0]   tx_frame;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mdrop_rx_filter #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_frame(rx_frame),
    .node_addr(node_addr), .rearm(rearm), .out_valid(out_valid),
    .out_data(out_data), .out_is_addr(out_is_addr), .addr_match(addr_match),
    .filter_on(filter_on), .tx_req(tx_req), .tx_is_addr(tx_is_addr),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_frame(tx_frame),
    .tx_stop2(tx_stop2)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, sample just after the rising edge.
  task automatic cyc(input bit v, input bit flag, input logic [DW-1:0] b, input bit rq);
    @(negedge clk);
    rx_valid = v;
    rx_frame = {flag, b};
    rearm    = rq;
    @(posedge clk);
    #1;
    rx_valid = 1'b0;
    rearm    = 1'b0;
  endtask

  task automatic select_node();
    cyc(1, 1, NODE, 0);
  endtask

  task automatic t_reset();
    check(filter_on == 1'b1, "R1 filter_on", filter_on, 1);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(addr_match == 1'b0, "R1 addr_match", addr_match, 0);
    check(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
  endtask

  task automatic t_filtered_data();
    cyc(1, 0, 8'h11, 0);
    check(out_valid == 1'b0, "R3 dropped", out_valid, 0);
    check(filter_on == 1'b1, "R3 still filtered", filter_on, 1);
    // payload equal to node address must not select (R2)
    cyc(1, 0, NODE, 0);
    check(addr_match == 1'b0 && out_valid == 1'b0, "R2 payload lookalike",
          {addr_match, out_valid}, 0);
    check(filter_on == 1'b1, "R2 filter kept", filter_on, 1);
  endtask

  task automatic t_foreign_addr();
    cyc(1, 1, 8'h33, 0);
    check(out_valid && out_is_addr && out_data == 8'h33, "R4 foreign addr delivered",
          {out_valid, out_is_addr, out_data}, {2'b11, 8'h33});
    check(addr_match == 1'b0 && filter_on == 1'b1, "R6 foreign addr",
          {addr_match, filter_on}, 1);
    cyc(1, 0, 8'h44, 0);
    check(out_valid == 1'b0, "R3 data after foreign addr", out_valid, 0);
  endtask

  task automatic t_select_and_receive();
    select_node();
    check(addr_match == 1'b1 && filter_on == 1'b0, "R5 match selects",
          {addr_match, filter_on}, 2);
    check(out_valid && out_is_addr && out_data == NODE, "R4 own addr delivered",
          {out_valid, out_is_addr, out_data}, {2'b11, NODE});
    for (int i = 0; i < 3; i++) begin
      logic [DW-1:0] b;
      b = 8'hA0 + 8'(i);
      cyc(1, 0, b, 0);
      check(out_valid && !out_is_addr && out_data == b, "R7 payload delivered",
            {out_valid, out_is_addr, out_data}, {2'b10, b});
      check(addr_match == 1'b0, "R5 match is a pulse", addr_match, 0);
    end
    cyc(0, 0, 8'h00, 0);
    check(out_valid == 1'b0 && filter_on == 1'b0, "R7 idle keeps selection",
          {out_valid, filter_on}, 0);
  endtask

  task automatic t_deselect_by_addr();
    select_node();
    cyc(1, 1, 8'h12, 0);
    check(filter_on == 1'b1 && addr_match == 1'b0, "R6 deselect while selected",
          {filter_on, addr_match}, 2);
    cyc(1, 0, 8'h55, 0);
    check(out_valid == 1'b0, "R6 data ignored after deselect", out_valid, 0);
  endtask

  task automatic t_rearm();
    select_node();
    cyc(0, 0, 8'h00, 1);
    check(filter_on == 1'b1 && out_valid == 1'b0, "R8 rearm alone",
          {filter_on, out_valid}, 2);
    select_node();
    cyc(1, 0, 8'h77, 1);
    check(out_valid == 1'b0 && filter_on == 1'b1, "R8 rearm beats data",
          {out_valid, filter_on}, 1);
  endtask

  task automatic t_addr_with_rearm();
    cyc(1, 1, NODE, 1);
    check(filter_on == 1'b0 && addr_match == 1'b1, "R9 matching addr with rearm",
          {filter_on, addr_match}, 1);
    cyc(1, 1, 8'h01, 1);
    check(filter_on == 1'b1 && out_valid == 1'b1, "R9 foreign addr with rearm",
          {filter_on, out_valid}, 3);
  endtask

  task automatic t_tx();
    check(tx_stop2 == 1'b0, "R11 nine-bit mode stop bits", tx_stop2, 0);
    @(negedge clk);
    tx_req = 1'b1; tx_is_addr = 1'b1; tx_byte = 8'h3C;
    @(posedge clk); #1;
    tx_req = 1'b0;
    check(tx_valid && tx_frame == {1'b1, 8'h3C}, "R10 addr char sent (filtered)",
          {tx_valid, tx_frame}, {1'b1, 1'b1, 8'h3C});
    select_node();
    check(tx_valid == 1'b0, "R10 tx idle", tx_valid, 0);
    @(negedge clk);
    tx_req = 1'b1; tx_is_addr = 1'b0; tx_byte = 8'hC3;
    @(posedge clk); #1;
    tx_req = 1'b0;
    check(tx_valid && tx_frame == {1'b0, 8'hC3}, "R10 data char sent (selected)",
          {tx_valid, tx_frame}, {1'b1, 1'b0, 8'hC3});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_filtered_data();
    t_foreign_addr();
    t_select_and_receive();
    t_deselect_by_addr();
    t_rearm();
    t_addr_with_rearm();
    t_tx();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule